// File: doc/BRIEF.md
# Backplane Slave Address Attach Logic

This block is the slave-side front end of a module on a multi-master backplane whose 32 address/data lines carry both addresses and data. The block watches those lines, the enable-geographic line, the address-sync strobe and three mode-select lines. On the first clock in which address-sync is seen high it decides whether this module takes part in the lock. The lock can be formed geographically, by the hardwired slot number. It can be formed logically, by an address that software has programmed into the module. Or it can be formed by a broadcast, which attaches many slaves at once and is decoded from an 8-bit function code.

While the lock holds, the block keeps the address space (control or data) that was chosen by the primary cycle. It runs data cycles framed by a data strobe. A data cycle can load or read a 32-bit secondary address, read the module type identifier, program the logical address, or move words in a small data-space store. Read data is driven through a registered output enable, which models an open-drain wired-OR line. Dropping address-sync ends the lock.

Top module: `bp_attach_slave`

## Requirements
- R1: After reset, ack, attached, bcast_att, ad_oe and space_data are 0, sec_addr is 0, and no logical address is loaded.
- R2: A primary cycle is the first clock edge at which addr_sync is sampled 1 after it was 0. A directed primary cycle has mode_sel[2:1]=00. With geo_en=1 it attaches when ad_in[4:0] equals slot_id; attached and ack are then 1 after that edge. A slot mismatch leaves both at 0.
- R3: At the first edge at which addr_sync is sampled 0, the block clears ack, attached and bcast_att.
- R4: mode_sel[0] sampled at the primary cycle (0 selects control space, 1 selects data space) appears on space_data. It stays fixed for the whole lock.
- R5: A read data cycle in control space, with mode_sel=000 and sec_addr=0, returns {16'h0, MODULE_ID}.
- R6: A write data cycle with mode_sel=001 loads ad_in into sec_addr at the strobe edge. A read data cycle with mode_sel=001 returns sec_addr.
- R7: A control-space write with mode_sel=000 and sec_addr=1 loads the logical address (ad_in[LA_W-1:0]) only in a geographic lock. In a logical or broadcast lock that write has no effect. A control-space read at sec_addr=1 returns the logical address.
- R8: A directed primary cycle with geo_en=0 attaches, and raises ack, only once a logical address has been loaded and ad_in[LA_W-1:0] equals it.
- R9: A primary cycle with mode_sel[2:1]=01 is a broadcast, and its function code is ad_in[7:0]. Code 00 attaches every slave. Code 01 attaches only a slave that holds a loaded logical address. A broadcast lock raises attached and bcast_att but never ack.
- R10: Broadcast codes F8 to FF are user codes. A user code attaches only when bit (code-F8) of USER_BCAST_MASK is 1; the default mask is 8'h05. Codes 02 to F7, and masked user codes, are ignored.
- R11: In a data-space lock, a write with mode_sel=000 stores ad_in at word sec_addr[IDX_W-1:0]. A read with mode_sel=000 returns that word. A broadcast write stores the word in the same way.
- R12: A read data cycle in a lock sets ad_oe to 1, with ad_out valid, one edge after the strobe is sampled rising. ad_oe returns to 0 at the first edge at which the data strobe, addr_sync or the lock is gone. Writes, and strobes without a lock, never set ad_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slot_id | input | 5 | Hardwired slot number |
| ad_in | input | 32 | Received address/data lines |
| geo_en | input | 1 | Enable-geographic line |
| addr_sync | input | 1 | Address-sync strobe |
| mode_sel | input | 3 | Mode-select lines |
| dstrobe | input | 1 | Data-cycle strobe |
| rd_nwr | input | 1 | 1 = read data cycle, 0 = write |
| ack | output | 1 | Address acknowledge (active high) |
| attached | output | 1 | Module is part of the current lock |
| bcast_att | output | 1 | Lock was formed by a broadcast |
| space_data | output | 1 | Lock space: 0 control, 1 data |
| sec_addr | output | 32 | Secondary address register |
| ad_out | output | 32 | Read data towards the wired-OR lines |
| ad_oe | output | 1 | Read data drive enable |

## Verification
Attach, ack and space_data follow the primary-cycle edge by one clock, and the release follows the first low sample of addr_sync by one clock. The bench drives the inputs on a falling edge and samples on the next falling edge, so each check falls half a period after the register that carries the result. Read data and ad_oe are due one edge after the strobe is sampled rising, and they fall one edge after the strobe drops; each read task samples at both of those points. Register writes land at the strobe edge and are observed later through read cycles or sec_addr. A mixed random phase checks attach decisions and data-space contents against a bench model of the store.

// File: rtl/bp_attach_pkg.sv
package bp_attach_pkg;

  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_GEO  = 2'd1,
    LK_LOG  = 2'd2,
    LK_BC   = 2'd3
  } lock_kind_e;

  localparam logic [1:0] MS_DIRECT  = 2'b00;
  localparam logic [1:0] MS_BCAST   = 2'b01;
  localparam logic [2:0] MS_DATA    = 3'b000;
  localparam logic [2:0] MS_SECADR  = 3'b001;
  localparam logic [7:0] BC_ALL     = 8'h00;
  localparam logic [7:0] BC_LOGICAL = 8'h01;

  function automatic logic geo_hit(input logic [4:0] slot, input logic [31:0] ad);
    return ad[4:0] == slot;
  endfunction

  function automatic logic bcast_hit(input logic [7:0] fn, input logic lad_ok,
                                     input logic [7:0] umask);
    logic r;
    if (fn == BC_ALL)             r = 1'b1;
    else if (fn == BC_LOGICAL)    r = lad_ok;
    else if (fn[7:3] == 5'h1F)    r = umask[fn[2:0]];
    else                          r = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/bp_prim_decode.sv
module bp_prim_decode
  import bp_attach_pkg::*;
#(
  parameter int         LA_W      = 16,
  parameter logic [7:0] USER_MASK = 8'h05
) (
  input  logic [4:0]      slot_id,
  input  logic [31:0]     ad_in,
  input  logic            geo_en,
  input  logic [1:0]      mode_hi,
  input  logic [LA_W-1:0] lad,
  input  logic            lad_valid,
  output logic            hit,
  output lock_kind_e      kind
);

  always_comb begin
    hit  = 1'b0;
    kind = LK_NONE;
    if (mode_hi == MS_DIRECT) begin
      if (geo_en) begin
        hit  = geo_hit(slot_id, ad_in);
        kind = LK_GEO;
      end else begin
        hit  = lad_valid && (ad_in[LA_W-1:0] == lad);
        kind = LK_LOG;
      end
    end else if (mode_hi == MS_BCAST) begin
      hit  = bcast_hit(ad_in[7:0], lad_valid, USER_MASK);
      kind = LK_BC;
    end
  end

endmodule

// File: rtl/bp_lock_ctrl.sv
module bp_lock_ctrl
  import bp_attach_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_sync,
  input  logic       hit,
  input  lock_kind_e kind_in,
  input  logic       space_in,
  output logic       prim_evt,
  output logic       attached,
  output lock_kind_e kind_q,
  output logic       space_q
);

  logic as_q;

  assign prim_evt = addr_sync && !as_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q     <= 1'b0;
      attached <= 1'b0;
      kind_q   <= LK_NONE;
      space_q  <= 1'b0;
    end else begin
      as_q <= addr_sync;
      if (!addr_sync) begin
        attached <= 1'b0;
        kind_q   <= LK_NONE;
        space_q  <= 1'b0;
      end else if (prim_evt && hit) begin
        attached <= 1'b1;
        kind_q   <= kind_in;
        space_q  <= space_in;
      end
    end
  end

endmodule

// File: rtl/bp_slave_regs.sv
module bp_slave_regs
  import bp_attach_pkg::*;
#(
  parameter int          LA_W      = 16,
  parameter int          MEM_DEPTH = 8,
  parameter logic [15:0] MODULE_ID = 16'hB7A3,
  localparam int         IDX_W     = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            data_evt,
  input  logic            rd_nwr,
  input  logic [2:0]      mode_sel,
  input  logic [31:0]     ad_in,
  input  lock_kind_e      kind_q,
  input  logic            space_q,
  output logic [LA_W-1:0] lad,
  output logic            lad_valid,
  output logic [31:0]     sec_addr,
  output logic [31:0]     rdata
);

  logic [31:0]      mem [MEM_DEPTH];
  logic [IDX_W-1:0] idx;
  logic             wr_evt;

  assign idx    = sec_addr[IDX_W-1:0];
  assign wr_evt = data_evt && !rd_nwr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_addr  <= '0;
      lad       <= '0;
      lad_valid <= 1'b0;
    end else if (wr_evt) begin
      if (mode_sel == MS_SECADR) begin
        sec_addr <= ad_in;
      end else if (mode_sel == MS_DATA && !space_q && sec_addr == 32'd1
                   && kind_q == LK_GEO) begin
        lad       <= ad_in[LA_W-1:0];
        lad_valid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
    end else if (wr_evt && mode_sel == MS_DATA && space_q) begin
      mem[idx] <= ad_in;
    end
  end

  always_comb begin
    rdata = '0;
    if (mode_sel == MS_SECADR) begin
      rdata = sec_addr;
    end else if (space_q) begin
      rdata = mem[idx];
    end else if (sec_addr == 32'd0) begin
      rdata = {16'h0, MODULE_ID};
    end else if (sec_addr == 32'd1) begin
      rdata = 32'(lad);
    end
  end

endmodule

// File: rtl/bp_attach_slave.sv
module bp_attach_slave
  import bp_attach_pkg::*;
#(
  parameter int          LA_W            = 16,
  parameter int          MEM_DEPTH       = 8,
  parameter logic [15:0] MODULE_ID       = 16'hB7A3,
  parameter logic [7:0]  USER_BCAST_MASK = 8'h05
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  slot_id,
  input  logic [31:0] ad_in,
  input  logic        geo_en,
  input  logic        addr_sync,
  input  logic [2:0]  mode_sel,
  input  logic        dstrobe,
  input  logic        rd_nwr,
  output logic        ack,
  output logic        attached,
  output logic        bcast_att,
  output logic        space_data,
  output logic [31:0] sec_addr,
  output logic [31:0] ad_out,
  output logic        ad_oe
);

  logic            hit;
  lock_kind_e      kind_d;
  lock_kind_e      kind_q;
  logic            prim_evt;
  logic            data_evt;
  logic            ds_q;
  logic [LA_W-1:0] lad_q;
  logic            lad_valid;
  logic [31:0]     rdata;

  bp_prim_decode #(.LA_W(LA_W), .USER_MASK(USER_BCAST_MASK)) u_dec (
    .slot_id(slot_id), .ad_in(ad_in), .geo_en(geo_en), .mode_hi(mode_sel[2:1]),
    .lad(lad_q), .lad_valid(lad_valid), .hit(hit), .kind(kind_d)
  );

  bp_lock_ctrl u_lock (
    .clk(clk), .rst_n(rst_n), .addr_sync(addr_sync), .hit(hit),
    .kind_in(kind_d), .space_in(mode_sel[0]), .prim_evt(prim_evt),
    .attached(attached), .kind_q(kind_q), .space_q(space_data)
  );

  assign data_evt = dstrobe && !ds_q && attached && addr_sync;

  bp_slave_regs #(.LA_W(LA_W), .MEM_DEPTH(MEM_DEPTH), .MODULE_ID(MODULE_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .data_evt(data_evt), .rd_nwr(rd_nwr),
    .mode_sel(mode_sel), .ad_in(ad_in), .kind_q(kind_q), .space_q(space_data),
    .lad(lad_q), .lad_valid(lad_valid), .sec_addr(sec_addr), .rdata(rdata)
  );

  assign ack       = attached && (kind_q != LK_BC);
  assign bcast_att = attached && (kind_q == LK_BC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ds_q   <= 1'b0;
      ad_oe  <= 1'b0;
      ad_out <= '0;
    end else begin
      ds_q <= dstrobe;
      if (!dstrobe || !addr_sync || !attached) begin
        ad_oe <= 1'b0;
      end else if (data_evt && rd_nwr) begin
        ad_oe  <= 1'b1;
        ad_out <= rdata;
      end
    end
  end

endmodule

// File: rtl/bp_attach_chk.sv
module bp_attach_chk
  import bp_attach_pkg::*;
#(
  parameter int         LA_W      = 16,
  parameter logic [7:0] USER_MASK = 8'h05
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      slot_id,
  input logic [31:0]     ad_in,
  input logic            geo_en,
  input logic            addr_sync,
  input logic [2:0]      mode_sel,
  input logic            prim_evt,
  input logic            ack,
  input logic            attached,
  input logic            bcast_att,
  input logic            space_data,
  input logic            ad_oe,
  input lock_kind_e      kind_q,
  input logic [LA_W-1:0] lad_q
);

  AST_GEO_ATTACH: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_evt && geo_en && mode_sel[2:1] == MS_DIRECT && ad_in[4:0] == slot_id) |=> ack); // R2

  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_sync |=> (!ack && !attached && !bcast_att)); // R3

  AST_SPACE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (attached && addr_sync) |=> (!attached || $stable(space_data))); // R4

  AST_LAD_GEO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q != LK_GEO) |=> $stable(lad_q)); // R7

  AST_BCAST_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_att |-> !ack); // R9

  AST_USER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_evt && mode_sel[2:1] == MS_BCAST && ad_in[7:3] == 5'h1F
     && !USER_MASK[ad_in[2:0]]) |=> !attached); // R10

  AST_OE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> attached); // R12

endmodule

bind bp_attach_slave bp_attach_chk #(.LA_W(LA_W), .USER_MASK(USER_BCAST_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_id(slot_id), .ad_in(ad_in), .geo_en(geo_en),
  .addr_sync(addr_sync), .mode_sel(mode_sel), .prim_evt(prim_evt), .ack(ack),
  .attached(attached), .bcast_att(bcast_att), .space_data(space_data),
  .ad_oe(ad_oe), .kind_q(kind_q), .lad_q(lad_q)
);

// File: tb/bp_attach_slave_tb.sv
module bp_attach_slave_tb;

  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] ID         = 16'hB7A3;
  localparam logic [4:0]  SLOT       = 5'd13;
  localparam logic [15:0] LADV       = 16'h1879;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  slot_id = SLOT;
  logic [31:0] ad_in = '0;
  logic        geo_en = 1'b0, addr_sync = 1'b0, dstrobe = 1'b0, rd_nwr = 1'b0;
  logic [2:0]  mode_sel = '0;
  logic        ack, attached, bcast_att, space_data, ad_oe;
  logic [31:0] sec_addr, ad_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_mem [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  bp_attach_slave u_dut (
    .clk(clk), .rst_n(rst_n), .slot_id(slot_id), .ad_in(ad_in), .geo_en(geo_en),
    .addr_sync(addr_sync), .mode_sel(mode_sel), .dstrobe(dstrobe), .rd_nwr(rd_nwr),
    .ack(ack), .attached(attached), .bcast_att(bcast_att), .space_data(space_data),
    .sec_addr(sec_addr), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  function automatic logic [31:0] ctl_expect(input logic [31:0] sa, input logic [15:0] la);
    if (sa == 0) return {16'h0, ID};
    if (sa == 1) return {16'h0, la};
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic prim(input bit g, input logic [2:0] ms, input logic [31:0] a);
    @(negedge clk);
    geo_en = g; mode_sel = ms; ad_in = a; addr_sync = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rel();
    @(negedge clk);
    addr_sync = 1'b0; geo_en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R3 ack after release", {31'h0, ack}, 32'h0);
    chk("R3 attached after release", {31'h0, attached}, 32'h0);
  endtask

  task automatic dwr(input logic [2:0] ms, input logic [31:0] d);
    @(negedge clk);
    dstrobe = 1'b1; rd_nwr = 1'b0; mode_sel = ms; ad_in = d;
    @(posedge clk); @(negedge clk);
    chk("R12 no drive on write", {31'h0, ad_oe}, 32'h0);
    dstrobe = 1'b0;
    @(posedge clk);
  endtask

  task automatic drd(input logic [2:0] ms, output logic [31:0] v, output logic oe);
    @(negedge clk);
    dstrobe = 1'b1; rd_nwr = 1'b1; mode_sel = ms;
    @(posedge clk); @(negedge clk);
    v = ad_out; oe = ad_oe;
    dstrobe = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R12 drive released", {31'h0, ad_oe}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic oe;
    logic [15:0] la_model;
    int unsigned seed;
    seed = $urandom(32'd4242);
    la_model = '0;
    for (int i = 0; i < 8; i++) exp_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ack", {31'h0, ack}, 32'h0);
    chk("R1 attached", {31'h0, attached}, 32'h0);
    chk("R1 oe", {31'h0, ad_oe}, 32'h0);
    chk("R1 sec_addr", sec_addr, 32'h0);
    chk("R1 space", {31'h0, space_data}, 32'h0);

    // R9 code 01 before any logical address: ignored
    prim(0, 3'b010, 32'h01);
    chk("R9 bc01 without lad", {31'h0, attached}, 32'h0);
    rel();
    // R8 logical before load
    prim(0, 3'b000, 32'h0);
    chk("R8 logical before load", {31'h0, attached}, 32'h0);
    rel();
    // R12 strobe without lock
    drd(3'b000, v, oe);
    chk("R12 no lock no drive", {31'h0, oe}, 32'h0);
    // R2 mismatch
    prim(1, 3'b000, {27'h0, SLOT ^ 5'd1});
    chk("R2 geo mismatch", {31'h0, ack}, 32'h0);
    rel();
    // R2 geo match, control space
    prim(1, 3'b000, {27'h0, SLOT});
    chk("R2 geo ack", {31'h0, ack}, 32'h1);
    chk("R4 control space", {31'h0, space_data}, 32'h0);
    drd(3'b000, v, oe);
    chk("R5 id value", v, {16'h0, ID});
    chk("R12 read drives", {31'h0, oe}, 32'h1);
    dwr(3'b001, 32'h1);
    chk("R6 sec_addr loaded", sec_addr, 32'h1);
    drd(3'b001, v, oe);
    chk("R6 sec readback", v, 32'h1);
    dwr(3'b000, {16'hABCD, LADV});
    la_model = LADV;
    drd(3'b000, v, oe);
    chk("R7 lad readback", v, {16'h0, LADV});
    rel();
    // R8 logical attach
    prim(0, 3'b000, {16'h0, LADV});
    chk("R8 logical ack", {31'h0, ack}, 32'h1);
    dwr(3'b001, 32'h1);
    dwr(3'b000, 32'h0000_2222);
    rel();
    prim(1, 3'b000, {27'h0, SLOT});
    dwr(3'b001, 32'h1);
    drd(3'b000, v, oe);
    chk("R7 write in logical lock ignored", v, {16'h0, LADV});
    rel();
    // R9 broadcast all, data space
    prim(0, 3'b011, 32'h00);
    chk("R9 bc00 attached", {31'h0, attached}, 32'h1);
    chk("R9 bc00 no ack", {31'h0, ack}, 32'h0);
    chk("R9 bc flag", {31'h0, bcast_att}, 32'h1);
    chk("R4 data space", {31'h0, space_data}, 32'h1);
    dwr(3'b001, 32'h3);
    dwr(3'b000, 32'hDEAD_BEEF);
    exp_mem[3] = 32'hDEAD_BEEF;
    drd(3'b000, v, oe);
    chk("R11 bcast write stored", v, 32'hDEAD_BEEF);
    rel();
    prim(0, 3'b010, 32'h01);
    chk("R9 bc01 with lad", {31'h0, attached}, 32'h1);
    rel();
    // R10 user codes
    prim(0, 3'b010, 32'hF8);
    chk("R10 F8 enabled", {31'h0, attached}, 32'h1);
    rel();
    prim(0, 3'b010, 32'hFA);
    chk("R10 FA enabled", {31'h0, attached}, 32'h1);
    rel();
    prim(0, 3'b010, 32'hF9);
    chk("R10 F9 masked", {31'h0, attached}, 32'h0);
    rel();
    prim(0, 3'b010, 32'h40);
    chk("R10 undefined code", {31'h0, attached}, 32'h0);
    rel();

    // mixed random phase
    for (int it = 0; it < 40; it++) begin
      int unsigned r;
      logic sp;
      logic [2:0] ix;
      logic [31:0] w;
      r = $urandom % 4;
      if (r == 0) begin
        prim(1, 3'b000, {$urandom, 5'h0} | {27'h0, SLOT ^ 5'(1 + $urandom % 31)});
        chk("R2 random mismatch", {31'h0, attached}, 32'h0);
      end else begin
        sp = 1'($urandom % 2);
        prim(1, {2'b00, sp}, {$urandom, 5'h0} | {27'h0, SLOT});
        chk("R2 random attach", {31'h0, ack}, 32'h1);
        chk("R4 random space", {31'h0, space_data}, {31'h0, sp});
        ix = 3'($urandom % 8);
        dwr(3'b001, {29'h0, ix});
        if (sp) begin
          w = $urandom;
          dwr(3'b000, w);
          exp_mem[ix] = w;
          drd(3'b000, v, oe);
          chk("R11 random data word", v, exp_mem[ix]);
        end else begin
          drd(3'b000, v, oe);
          chk("R5 random control read", v, ctl_expect({29'h0, ix}, la_model));
        end
      end
      rel();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule